// File: doc/BRIEF.md
# SPI Shadow Register Sync Controller

This block holds a local shadow of a peripheral's configuration registers and keeps the peripheral in step with it by sending over SPI only what has changed. A host writes the shadow through a simple write port. Each write that changes a stored value marks its group as dirty. The controller then drives an SPI master engine through a command interface. That interface carries a frame header (a read/write bit and a start address), a byte count, the total frame length in bits, a byte stream that advances on request, and start and done strobes.

Work is served in a fixed order. The peripheral's mode register comes first. Its last known value is tracked, and it is rewritten to 0x3C whenever that value differs. A three-register write group at 0x020 to 0x022 goes out as one address-streaming burst. A 96-byte lookup table at 0x100 to 0x15F goes out as two 48-byte bursts. A dummy single write to the unused address 0x00A follows each burst so that the bus returns to standard 24-bit framing. Last, each changed register of a small individual set at 0x010 to 0x017 is written on its own.

Top module: `spi_shadow_sync`

## Requirements
- R1: While reset is held, `cmd_start` is 0. The first transaction after reset is a single write of 0x3C to address 0x000, because the tracked mode value resets to 0x00.
- R2: A host write whose data equals the value already in the shadow starts no transaction.
- R3: A host write to 0x000 records the peripheral's current mode value. If that value is not 0x3C, a single write of 0x3C to 0x000 follows. Once that write completes, or if the value already is 0x3C, no mode write is sent.
- R4: A change to any register in 0x020 to 0x022 produces one burst with start address 0x020 and length 3. It carries the shadow bytes of 0x020, 0x021 and 0x022 in that order.
- R5: Every header has bit 15 = 0, which is the write flag and the first bit shifted, and bits 14:0 = the start address. `cmd_nbits` equals 16 + 8 × `cmd_len`: 40 for the write-group burst and 24 for a single write.
- R6: The transaction that follows a write-group burst is a single write of 0x00 to address 0x00A.
- R7: A change anywhere in 0x100 to 0x15F produces a 48-byte burst at 0x100, then a 48-byte burst at 0x130, then a single write of 0x00 to 0x00A. The bursts carry the table bytes in ascending address order.
- R8: Each changed register in 0x010 to 0x017 gets its own single write. When several are pending, the lowest address goes first.
- R9: When the controller is free, pending work is picked in the order mode register, write group, lookup table, individual registers.
- R10: A group's dirty state clears only when its burst completes. A change made to that group while its burst is in flight causes the group to be sent again.
- R11: Host writes to addresses outside 0x000, 0x010 to 0x017, 0x020 to 0x022 and 0x100 to 0x15F cause no transaction.
- R12: `cmd_start` is a one-cycle pulse. Header and length hold steady until `cmd_done`. `cmd_byte` moves to the next byte on each `cmd_next` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Shadow write strobe |
| host_addr | input | 15 | Shadow write address |
| host_wdata | input | 8 | Shadow write data |
| cmd_start | output | 1 | One-cycle request to the SPI engine to begin a frame |
| cmd_hdr | output | 16 | Frame header: bit 15 read/write (0 = write), bits 14:0 start address |
| cmd_len | output | 8 | Number of data bytes in the frame |
| cmd_nbits | output | 12 | Total frame length in bits |
| cmd_byte | output | 8 | Current data byte of the stream |
| cmd_next | input | 1 | Engine has taken `cmd_byte`; advance to the next byte |
| cmd_done | input | 1 | Engine has finished the frame |

## Verification
The bench first sends writes that should produce nothing: unchanged values, addresses just outside every group, the dummy address, and 0x3C to the mode register. These separate real change detection from plain address decode. Single changes are then swept over every write-group register and over the first and last entries of each lookup-table half. This shows that one change anywhere in a group sends the whole fixed burst set with the right start addresses and byte order. By holding `cmd_done` back, the bench stacks up work from all four classes, and also lands writes inside a burst that is in flight. The first exposes the service order. The second tells a flag cleared at completion apart from one cleared at launch.

// File: rtl/spi_sync_pkg.sv
// Shared widths and state encodings for the SPI shadow sync controller.
package spi_sync_pkg;
    localparam int ADDR_W  = 15;
    localparam int DATA_W  = 8;
    localparam int HDR_W   = ADDR_W + 1;
    localparam int LEN_W   = 8;
    localparam int NBITS_W = 12;

    // Kind of frame currently being launched or in flight.
    typedef enum logic [2:0] {
        J_MODE  = 3'd0,
        J_WR    = 3'd1,
        J_LUT   = 3'd2,
        J_MISC  = 3'd3,
        J_DUMMY = 3'd4
    } job_e;

    // Command interface phase.
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } st_e;
endpackage

// File: rtl/sync_group_store.sv
// Shadow storage for one contiguous register group, with change detection
// and dirty tracking. PER_ENTRY=1 keeps one dirty bit per register; 0 keeps
// one bit for the whole group. A service window (svc_act .. svc_done) marks
// the entry or group being sent. A change to it inside the window re-arms its
// dirty bit, which is cleared at svc_done.
// Assumes svc_done is a single-cycle pulse that ends an svc_act window.
module sync_group_store
    import spi_sync_pkg::*;
#(
    parameter int BASE      = 32'h020,
    parameter int LEN       = 3,
    parameter int PER_ENTRY = 0,
    localparam int IDX_W    = (LEN > 1) ? $clog2(LEN) : 1,
    localparam int NDIRTY   = (PER_ENTRY != 0) ? LEN : 1,
    localparam int DIDX_W   = (NDIRTY > 1) ? $clog2(NDIRTY) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              svc_act,
    input  logic [DIDX_W-1:0] svc_idx,
    input  logic              svc_done,
    output logic [NDIRTY-1:0] dirty
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + LEN);

    logic [DATA_W-1:0] mem [LEN];
    logic              hit;
    logic              changed;
    logic [IDX_W-1:0]  off;
    logic [DIDX_W-1:0] d_off;
    logic              rearm;
    logic [NDIRTY-1:0] dirty_nx;

    assign hit     = host_en && (host_addr >= LO) && (host_addr < HI);
    assign off     = IDX_W'(host_addr - LO);
    assign changed = hit && (mem[off] != host_data);
    assign rd_data = mem[rd_idx];

    // Select the variant that maps an entry offset to its dirty bit.
    generate
        if (PER_ENTRY != 0) begin : g_per_entry
            assign d_off = DIDX_W'(off);
        end else begin : g_whole_group
            assign d_off = '0;
        end
    endgenerate

    // Shadow storage: host writes land here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LEN; i++) mem[i] <= '0;
        end else if (hit) begin
            mem[off] <= host_data;
        end
    end

    // Re-arm: remembers a change to the entry being sent inside its window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        rearm <= 1'b0;
        else if (svc_done)                                 rearm <= 1'b0;
        else if (svc_act && changed && (d_off == svc_idx)) rearm <= 1'b1;
    end

    // Next dirty vector: clear served entry at completion, set on change.
    always_comb begin
        dirty_nx = dirty;
        if (svc_done) dirty_nx[svc_idx] = rearm;
        if (changed)  dirty_nx[d_off]   = 1'b1;
    end

    // Dirty register.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty <= '0;
        else        dirty <= dirty_nx;
    end

    a_r2_same_value_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !changed && !svc_done) |=> (dirty == $past(dirty)));

    a_r10_change_marks: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> dirty[$past(d_off)]);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && !rearm && !changed) |=> !dirty[$past(svc_idx)]);
endmodule

// File: rtl/sync_frame_sched.sv
// Frame scheduler: picks the next unit of work in fixed priority order,
// launches it on the command interface and chains the follow-on frames
// (second table burst, dummy write) without returning to idle.
// Assumes the engine raises cmd_done once, after it has taken all bytes.
module sync_frame_sched
    import spi_sync_pkg::*;
#(
    parameter int WR_BASE    = 32'h020,
    parameter int WR_LEN     = 3,
    parameter int LUT_BASE   = 32'h100,
    parameter int LUT_BURST  = 48,
    parameter int LUT_BURSTS = 2,
    parameter int MISC_BASE  = 32'h010,
    parameter int MISC_CNT   = 8,
    parameter int MODE_ADDR  = 32'h000,
    parameter int DUMMY_ADDR = 32'h00A,
    localparam int K_W       = (LUT_BURSTS > 1) ? $clog2(LUT_BURSTS) : 1,
    localparam int MS_W      = (MISC_CNT > 1) ? $clog2(MISC_CNT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_need,
    input  logic               wr_dirty,
    input  logic               lut_dirty,
    input  logic [MISC_CNT-1:0] misc_dirty,
    input  logic               cmd_done,
    input  logic               cmd_next,
    output logic               cmd_start,
    output logic [HDR_W-1:0]   cmd_hdr,
    output logic [LEN_W-1:0]   cmd_len,
    output logic [NBITS_W-1:0] cmd_nbits,
    output job_e               job,
    output logic [K_W-1:0]     lut_k,
    output logic [MS_W-1:0]    misc_sel,
    output logic [LEN_W-1:0]   byte_idx,
    output logic               mode_fin,
    output logic               wr_act,
    output logic               wr_fin,
    output logic               lut_act,
    output logic               lut_fin,
    output logic               misc_act,
    output logic               misc_fin
);
    localparam logic [K_W-1:0] K_LAST = K_W'(LUT_BURSTS - 1);

    st_e               st;
    logic              done_evt;
    logic              go;
    job_e              nj;
    logic [K_W-1:0]    nk;
    logic [MS_W-1:0]   ns;
    logic [MS_W-1:0]   pe;
    logic [ADDR_W-1:0] naddr;
    logic [LEN_W-1:0]  nlen;

    assign done_evt  = (st == S_WAIT) && cmd_done;
    assign cmd_start = (st == S_LAUNCH);

    // Lowest-index pending individual register.
    always_comb begin
        pe = '0;
        for (int i = MISC_CNT - 1; i >= 0; i--) begin
            if (misc_dirty[i]) pe = MS_W'(i);
        end
    end

    // Next-frame decision: priority pick when idle, chaining on completion.
    always_comb begin
        go = 1'b0;
        nj = job;
        nk = lut_k;
        ns = misc_sel;
        if (st == S_IDLE) begin
            if (mode_need) begin
                go = 1'b1; nj = J_MODE;
            end else if (wr_dirty) begin
                go = 1'b1; nj = J_WR;
            end else if (lut_dirty) begin
                go = 1'b1; nj = J_LUT; nk = '0;
            end else if (|misc_dirty) begin
                go = 1'b1; nj = J_MISC; ns = pe;
            end
        end else if (done_evt) begin
            if (job == J_WR) begin
                go = 1'b1; nj = J_DUMMY;
            end else if (job == J_LUT) begin
                go = 1'b1;
                if (lut_k != K_LAST) begin
                    nj = J_LUT; nk = lut_k + K_W'(1);
                end else begin
                    nj = J_DUMMY;
                end
            end
        end
    end

    // Start address and byte count of the frame about to launch.
    always_comb begin
        case (nj)
            J_MODE:  begin naddr = ADDR_W'(MODE_ADDR);  nlen = LEN_W'(1); end
            J_WR:    begin naddr = ADDR_W'(WR_BASE);    nlen = LEN_W'(WR_LEN); end
            J_LUT:   begin naddr = ADDR_W'(LUT_BASE + int'(nk) * LUT_BURST);
                           nlen  = LEN_W'(LUT_BURST); end
            J_MISC:  begin naddr = ADDR_W'(MISC_BASE + int'(ns)); nlen = LEN_W'(1); end
            default: begin naddr = ADDR_W'(DUMMY_ADDR); nlen = LEN_W'(1); end
        endcase
    end

    // Command phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n)                st <= S_IDLE;
        else if (go)               st <= S_LAUNCH;
        else if (st == S_LAUNCH)   st <= S_WAIT;
        else if (done_evt)         st <= S_IDLE;
    end

    // Frame descriptor registers, loaded at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job       <= J_MODE;
            lut_k     <= '0;
            misc_sel  <= '0;
            cmd_hdr   <= '0;
            cmd_len   <= '0;
            cmd_nbits <= '0;
        end else if (go) begin
            job       <= nj;
            lut_k     <= nk;
            misc_sel  <= ns;
            cmd_hdr   <= {1'b0, naddr};
            cmd_len   <= nlen;
            cmd_nbits <= NBITS_W'(HDR_W + DATA_W * int'(nlen));
        end
    end

    // Byte stream position: restarts at launch, steps on each engine request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                byte_idx <= '0;
        else if (go)                               byte_idx <= '0;
        else if (cmd_next && (byte_idx < cmd_len)) byte_idx <= byte_idx + LEN_W'(1);
    end

    assign mode_fin = done_evt && (job == J_MODE);
    assign wr_act   = (st != S_IDLE) && (job == J_WR);
    assign wr_fin   = done_evt && (job == J_WR);
    assign lut_act  = (st != S_IDLE) && (job == J_LUT);
    assign lut_fin  = done_evt && (job == J_LUT) && (lut_k == K_LAST);
    assign misc_act = (st != S_IDLE) && (job == J_MISC);
    assign misc_fin = done_evt && (job == J_MISC);

    a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    a_r12_hdr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) |-> ($stable(cmd_hdr) && $stable(cmd_len)));

    a_r5_write_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> !cmd_hdr[HDR_W-1]);

    a_r5_nbits: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (int'(cmd_nbits) == HDR_W + DATA_W * int'(cmd_len)));

    a_r9_mode_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_IDLE) && mode_need) |=>
            (cmd_start && (cmd_hdr[ADDR_W-1:0] == ADDR_W'(MODE_ADDR))));

    a_r6_dummy_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && (job == J_WR)) |=>
            (cmd_start && (cmd_hdr[ADDR_W-1:0] == ADDR_W'(DUMMY_ADDR))));
endmodule

// File: rtl/sync_byte_sel.sv
// Byte stream source: maps the active frame kind and stream position onto
// the read port of the matching shadow group. Purely combinational.
// Assumes byte_idx stays below the frame length while bytes are taken.
module sync_byte_sel
    import spi_sync_pkg::*;
#(
    parameter int            WR_LEN     = 3,
    parameter int            LUT_BURST  = 48,
    parameter int            LUT_BURSTS = 2,
    parameter logic [7:0]    MODE_VAL   = 8'h3C,
    localparam int K_W       = (LUT_BURSTS > 1) ? $clog2(LUT_BURSTS) : 1,
    localparam int WIDX_W    = (WR_LEN > 1) ? $clog2(WR_LEN) : 1,
    localparam int LIDX_W    = $clog2(LUT_BURST * LUT_BURSTS)
) (
    input  job_e              job,
    input  logic [K_W-1:0]    lut_k,
    input  logic [LEN_W-1:0]  byte_idx,
    input  logic [DATA_W-1:0] wr_rd,
    input  logic [DATA_W-1:0] lut_rd,
    input  logic [DATA_W-1:0] misc_rd,
    output logic [WIDX_W-1:0] wr_idx,
    output logic [LIDX_W-1:0] lut_idx,
    output logic [DATA_W-1:0] cmd_byte
);
    assign wr_idx  = WIDX_W'(byte_idx);
    assign lut_idx = LIDX_W'(int'(lut_k) * LUT_BURST + int'(byte_idx));

    // Data byte for the current frame kind.
    always_comb begin
        case (job)
            J_MODE:  cmd_byte = MODE_VAL;
            J_WR:    cmd_byte = wr_rd;
            J_LUT:   cmd_byte = lut_rd;
            J_MISC:  cmd_byte = misc_rd;
            default: cmd_byte = '0;
        endcase
    end
endmodule

// File: rtl/spi_shadow_sync.sv
// Top of the SPI shadow sync controller. Holds three shadow groups (write
// group, lookup table, individual registers), tracks the peripheral's mode
// value, and feeds an SPI master engine with change-driven frames.
// Assumes the engine follows the start/next/done handshake of the ports.
module spi_shadow_sync
    import spi_sync_pkg::*;
#(
    parameter int         WR_BASE    = 32'h020,
    parameter int         WR_LEN     = 3,
    parameter int         LUT_BASE   = 32'h100,
    parameter int         LUT_BURST  = 48,
    parameter int         LUT_BURSTS = 2,
    parameter int         MISC_BASE  = 32'h010,
    parameter int         MISC_CNT   = 8,
    parameter int         MODE_ADDR  = 32'h000,
    parameter logic [7:0] MODE_VAL   = 8'h3C,
    parameter int         DUMMY_ADDR = 32'h00A,
    localparam int LUT_LEN = LUT_BURST * LUT_BURSTS,
    localparam int K_W     = (LUT_BURSTS > 1) ? $clog2(LUT_BURSTS) : 1,
    localparam int MS_W    = (MISC_CNT > 1) ? $clog2(MISC_CNT) : 1,
    localparam int WIDX_W  = (WR_LEN > 1) ? $clog2(WR_LEN) : 1,
    localparam int LIDX_W  = $clog2(LUT_LEN)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_we,
    input  logic [14:0]  host_addr,
    input  logic [7:0]   host_wdata,
    output logic         cmd_start,
    output logic [15:0]  cmd_hdr,
    output logic [7:0]   cmd_len,
    output logic [11:0]  cmd_nbits,
    output logic [7:0]   cmd_byte,
    input  logic         cmd_next,
    input  logic         cmd_done
);
    logic [DATA_W-1:0]   mode_seen;
    logic                mode_need;
    logic                wr_dirty;
    logic                lut_dirty;
    logic [MISC_CNT-1:0] misc_dirty;
    job_e                job;
    logic [K_W-1:0]      lut_k;
    logic [MS_W-1:0]     misc_sel;
    logic [LEN_W-1:0]    byte_idx;
    logic                mode_fin, wr_act, wr_fin, lut_act, lut_fin, misc_act, misc_fin;
    logic [WIDX_W-1:0]   wr_idx;
    logic [LIDX_W-1:0]   lut_idx;
    logic [DATA_W-1:0]   wr_rd, lut_rd, misc_rd;

    // Last known mode value of the peripheral: host reports, restore confirms.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                mode_seen <= '0;
        else if (host_we && (host_addr == ADDR_W'(MODE_ADDR)))     mode_seen <= host_wdata;
        else if (mode_fin)                                         mode_seen <= MODE_VAL;
    end

    assign mode_need = (mode_seen != MODE_VAL);

    sync_group_store #(.BASE(WR_BASE), .LEN(WR_LEN), .PER_ENTRY(0)) u_wr_store (
        .clk, .rst_n,
        .host_en(host_we), .host_addr, .host_data(host_wdata),
        .rd_idx(wr_idx), .rd_data(wr_rd),
        .svc_act(wr_act), .svc_idx(1'b0), .svc_done(wr_fin),
        .dirty(wr_dirty)
    );

    sync_group_store #(.BASE(LUT_BASE), .LEN(LUT_LEN), .PER_ENTRY(0)) u_lut_store (
        .clk, .rst_n,
        .host_en(host_we), .host_addr, .host_data(host_wdata),
        .rd_idx(lut_idx), .rd_data(lut_rd),
        .svc_act(lut_act), .svc_idx(1'b0), .svc_done(lut_fin),
        .dirty(lut_dirty)
    );

    sync_group_store #(.BASE(MISC_BASE), .LEN(MISC_CNT), .PER_ENTRY(1)) u_misc_store (
        .clk, .rst_n,
        .host_en(host_we), .host_addr, .host_data(host_wdata),
        .rd_idx(misc_sel), .rd_data(misc_rd),
        .svc_act(misc_act), .svc_idx(misc_sel), .svc_done(misc_fin),
        .dirty(misc_dirty)
    );

    sync_frame_sched #(
        .WR_BASE(WR_BASE), .WR_LEN(WR_LEN), .LUT_BASE(LUT_BASE),
        .LUT_BURST(LUT_BURST), .LUT_BURSTS(LUT_BURSTS),
        .MISC_BASE(MISC_BASE), .MISC_CNT(MISC_CNT),
        .MODE_ADDR(MODE_ADDR), .DUMMY_ADDR(DUMMY_ADDR)
    ) u_sched (
        .clk, .rst_n,
        .mode_need, .wr_dirty, .lut_dirty, .misc_dirty,
        .cmd_done, .cmd_next,
        .cmd_start, .cmd_hdr, .cmd_len, .cmd_nbits,
        .job, .lut_k, .misc_sel, .byte_idx,
        .mode_fin, .wr_act, .wr_fin, .lut_act, .lut_fin, .misc_act, .misc_fin
    );

    sync_byte_sel #(
        .WR_LEN(WR_LEN), .LUT_BURST(LUT_BURST), .LUT_BURSTS(LUT_BURSTS), .MODE_VAL(MODE_VAL)
    ) u_byte_sel (
        .job, .lut_k, .byte_idx, .wr_rd, .lut_rd, .misc_rd,
        .wr_idx, .lut_idx, .cmd_byte
    );

    a_r3_mode_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && (cmd_hdr[14:0] == 15'(MODE_ADDR))) |-> (cmd_byte == MODE_VAL));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !cmd_start);
endmodule

// File: tb/test_spi_shadow_sync.sv
module test_spi_shadow_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        cmd_start;
    logic [15:0] cmd_hdr;
    logic [7:0]  cmd_len;
    logic [11:0] cmd_nbits;
    logic [7:0]  cmd_byte;
    logic        cmd_next = 1'b0;
    logic        cmd_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit hold_done = 0;
    bit mbusy = 0;

    logic [7:0]  m [0:511];
    logic [15:0] log_hdr [0:63];
    int          log_len [0:63];
    int          log_nb  [0:63];
    logic [7:0]  log_b   [0:63][0:47];
    int          log_n = 0;

    spi_shadow_sync i_spi_shadow_sync (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata,
        .cmd_start, .cmd_hdr, .cmd_len, .cmd_nbits, .cmd_byte,
        .cmd_next, .cmd_done
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // SPI engine model: takes bytes, logs frames, optionally holds done back.
    initial begin
        @(posedge rst_n);
        @(negedge clk);
        forever begin
            if (cmd_start === 1'b1) begin
                mbusy = 1;
                log_hdr[log_n % 64] = cmd_hdr;
                log_len[log_n % 64] = int'(cmd_len);
                log_nb[log_n % 64]  = int'(cmd_nbits);
                for (int k = 0; k < int'(cmd_len); k++) begin
                    if (k < 48) log_b[log_n % 64][k] = cmd_byte;
                    cmd_next = 1'b1;
                    @(negedge clk);
                    cmd_next = 1'b0;
                    if (k == 0) chk("R12", "start pulse width", int'(cmd_start), 0);
                end
                while (hold_done) @(negedge clk);
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done = 1'b0;
                log_n++;
                mbusy = 0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic hw(int a, int d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = 15'(a);
        host_wdata = 8'(d);
        if (a < 512) m[a] = 8'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 20) begin
            @(negedge clk);
            if (cmd_start || mbusy || hold_done) q = 0;
            else q++;
        end
    endtask

    // kind 0: bytes from model at address; 1: all bytes equal cval; 2: skip bytes
    task automatic chk_txn(int i, string tag, int a, int l, int kind, int cval);
        int bad_k = -1;
        int exp_b = 0;
        n_chk++;
        if (i >= log_n) begin
            n_fail++;
            $display("FAIL %s frame %0d missing: actual 0x%0h expected 0x%0h", tag, i, log_n, i + 1);
            return;
        end
        n_n_dec();
        chk("R5", "write bit", int'(log_hdr[i][15]), 0);
        chk(tag, "start address", int'(log_hdr[i][14:0]), a);
        chk(tag, "byte count", log_len[i], l);
        chk("R5", "frame bits", log_nb[i], 16 + 8 * l);
        if (kind != 2) begin
            for (int k = 0; k < l && k < 48; k++) begin
                exp_b = (kind == 0) ? int'(m[a + k]) : cval;
                if (bad_k < 0 && int'(log_b[i][k]) != exp_b) bad_k = k;
            end
            if (bad_k < 0) chk(tag, "byte stream", 0, 0);
            else chk(tag, "byte stream", int'(log_b[i][bad_k]),
                     (kind == 0) ? int'(m[a + bad_k]) : cval);
        end
    endtask

    // The frame-present test above is counted through the following checks.
    task automatic n_n_dec();
        n_chk--;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) m[i] = 8'h00;
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", log_n, 0);
        finish_run();
    end

    initial begin
        int old_b;
        // R1: reset state and first frame
        repeat (5) @(negedge clk);
        chk("R1", "start in reset", int'(cmd_start), 0);
        rst_n = 1'b1;
        quiet();
        chk("R1", "frames after reset", log_n, 1);
        chk_txn(0, "R1", 0, 1, 1, 8'h3C);
        log_n = 0;

        // R2, R3, R11: writes that must send nothing
        hw(0, 8'h3C);
        hw(8'h10, 0);
        hw(8'h21, 0);
        hw(8'h50, 8'h12);
        hw(8'h0A, 8'h34);
        hw(8'h18, 8'h09);
        hw(8'h0F, 8'h07);
        hw(8'h23, 8'h01);
        hw(9'h0FF, 8'h02);
        hw(9'h160, 8'h01);
        hw(15'h7FFF, 8'h01);
        quiet();
        chk("R11", "frames for ignored writes", log_n, 0);
        log_n = 0;

        // R4, R6: sweep each write-group register
        for (int j = 0; j < 3; j++) begin
            hw(8'h20 + j, 8'h40 + 8'h11 * j);
            quiet();
            chk("R4", "frames per group change", log_n, 2);
            chk_txn(0, "R4", 8'h20, 3, 0, 0);
            chk_txn(1, "R6", 8'h0A, 1, 1, 0);
            log_n = 0;
        end

        // R7, R10: fill table while a burst is held, then boundary sweep
        hold_done = 1;
        hw(9'h100, 8'h01);
        for (int j = 0; j < 96; j++) hw(9'h100 + j, (j * 7 + 3) & 8'hFF);
        hold_done = 0;
        quiet();
        chk("R10", "frames after fill", log_n, 6);
        chk_txn(0, "R7", 9'h100, 48, 2, 0);
        chk_txn(2, "R7", 8'h0A, 1, 1, 0);
        chk_txn(3, "R10", 9'h100, 48, 0, 0);
        chk_txn(4, "R10", 9'h130, 48, 0, 0);
        chk_txn(5, "R7", 8'h0A, 1, 1, 0);
        log_n = 0;
        for (int j = 0; j < 4; j++) begin
            int a;
            a = (j == 0) ? 9'h100 : (j == 1) ? 9'h12F : (j == 2) ? 9'h130 : 9'h15F;
            hw(a, int'(~m[a]));
            quiet();
            chk("R7", "frames per table change", log_n, 3);
            chk_txn(0, "R7", 9'h100, 48, 0, 0);
            chk_txn(1, "R7", 9'h130, 48, 0, 0);
            chk_txn(2, "R7", 8'h0A, 1, 1, 0);
            log_n = 0;
        end

        // R8: individual registers, lowest address first
        hw(8'h13, 8'h11);
        quiet();
        chk("R8", "frames single", log_n, 1);
        chk_txn(0, "R8", 8'h13, 1, 0, 0);
        log_n = 0;
        hold_done = 1;
        hw(8'h17, 8'h01);
        hw(8'h16, 8'h02);
        hw(8'h10, 8'h03);
        hw(8'h15, 8'h04);
        hold_done = 0;
        quiet();
        chk("R8", "frames queued singles", log_n, 4);
        chk_txn(0, "R8", 8'h17, 1, 0, 0);
        chk_txn(1, "R8", 8'h10, 1, 0, 0);
        chk_txn(2, "R8", 8'h15, 1, 0, 0);
        chk_txn(3, "R8", 8'h16, 1, 0, 0);
        log_n = 0;

        // R9, R3: all classes pending at once
        hold_done = 1;
        hw(8'h11, 8'h5A);
        hw(9'h150, 8'hC3);
        hw(8'h22, 8'h3D);
        hw(0, 8'h81);
        hold_done = 0;
        quiet();
        chk("R9", "frames mixed", log_n, 7);
        chk_txn(0, "R8", 8'h11, 1, 0, 0);
        chk_txn(1, "R9", 0, 1, 1, 8'h3C);
        chk_txn(2, "R9", 8'h20, 3, 0, 0);
        chk_txn(3, "R6", 8'h0A, 1, 1, 0);
        chk_txn(4, "R9", 9'h100, 48, 0, 0);
        chk_txn(5, "R9", 9'h130, 48, 0, 0);
        chk_txn(6, "R7", 8'h0A, 1, 1, 0);
        log_n = 0;

        // R10: change inside an in-flight write-group burst
        old_b = int'(m[8'h22]);
        hold_done = 1;
        hw(8'h20, 8'h77);
        repeat (10) @(negedge clk);
        hw(8'h22, 8'h99);
        hold_done = 0;
        quiet();
        chk("R10", "frames after mid-burst change", log_n, 4);
        chk_txn(0, "R10", 8'h20, 3, 2, 0);
        chk("R10", "old byte in first burst", int'(log_b[0][2]), old_b);
        chk_txn(1, "R6", 8'h0A, 1, 1, 0);
        chk_txn(2, "R10", 8'h20, 3, 0, 0);
        chk_txn(3, "R6", 8'h0A, 1, 1, 0);
        log_n = 0;

        finish_run();
    end
endmodule